// File: doc/BRIEF.md
# Synchronous Buck Switching-Cycle Sequencer

This block is the digital timing core of a fixed-frequency, current-mode synchronous step-down converter. Each switching period starts with a one-cycle oscillator tick. On that tick the block releases the low-side switch, waits for the low-side gate to be sensed off, and then turns the high-side switch on. The high-side pulse ends when the peak-current comparator trips or when the on-time reaches its limit. The comparator is masked for a blanking window at the start of the pulse. After a fixed dead time the low-side switch is turned back on and stays on until the next tick.

The controller always runs in forced-PWM mode, so every period produces complementary drive. There is no pulse skipping and no diode emulation. Overcurrent is handled by valley limiting: when the low-side current flag is set at a tick, the whole high-side pulse is skipped and the low-side switch stays on.

A fault input forces both drives low at once. If the low-side-off sense never arrives, a timeout raises a flag and holds both drives low until the next tick. All timings are parameters counted in system-clock cycles.

Top module: `buck_pwm_core`

## Requirements
- R1: A tick (osc_tick_i high for one cycle) seen while the low-side switch is on and valley_lim_i is low starts a period: ls_en_o drops on the next cycle, and hs_en_o later turns on.
- R2: While the high-side switch is on, count its cycles from 0. If peak_trip_i is high in the cycle with count k, where BLANK_CYC <= k < MAX_ON_CYC, then hs_en_o stays high for exactly k+1 cycles.
- R3: A high peak_trip_i in a cycle with count below BLANK_CYC is ignored. A trip held from an earlier cycle ends the pulse after BLANK_CYC+1 cycles.
- R4: hs_en_o never stays high for more than MAX_ON_CYC consecutive cycles. Without a trip it stays high for exactly MAX_ON_CYC cycles.
- R5: If valley_lim_i is high during the tick, that period has no high-side pulse, and ls_en_o stays high for the whole period.
- R6: hs_en_o rises only in the cycle after ls_off_i was sampled high while both drives were low. A sense arriving after d low cycles gives exactly d cycles with both drives low before the pulse.
- R7: After hs_en_o falls, both drives stay low for exactly DEAD_CYC cycles, and then ls_en_o rises.
- R8: hs_en_o and ls_en_o are never high in the same cycle.
- R9: While fault_i is high, both drives are low in that same cycle. One cycle after fault_i falls, ls_en_o is high and hs_en_o is low.
- R10: If ls_off_i stays low for LS_TMO_CYC cycles after the low-side release, ls_timeout_o goes high. Both drives then stay low until the next tick, which clears ls_timeout_o and retries.
- R11: During reset both drives are low. One cycle after reset is released with no fault, ls_en_o is high.
- R12: In every period that is not interrupted by a fault or a timeout, ls_en_o is high at the end of the period, whatever the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | One-cycle pulse that starts a switching period |
| peak_trip_i | input | 1 | Peak-current comparator flag |
| valley_lim_i | input | 1 | Low-side valley current-limit flag, sampled at the tick |
| ls_off_i | input | 1 | Low-side gate sensed fully off |
| fault_i | input | 1 | Undervoltage or thermal fault |
| hs_en_o | output | 1 | High-side gate-drive enable |
| ls_en_o | output | 1 | Low-side gate-drive enable |
| ls_timeout_o | output | 1 | Low-side-off sense timed out in this period |

## Verification
The trip cycle is swept from the first cycle of the pulse to beyond the on-time limit. Each resulting pulse width therefore shows whether the trip was masked by blanking, acted on, or overtaken by the maximum on-time. The sense delay is varied alongside the sweep, which separates adaptive dead time from a fixed one. The fixed falling-edge gap is measured in every period.

Three further runs cover the paths away from normal switching. A valley flag at the tick must produce a period with no high-side pulse. A missing sense must end in the timeout hold. A fault raised in the middle of a pulse must drop both drives in the same cycle and recover with the low-side switch on.

// File: rtl/buck_pwm_pkg.sv
package buck_pwm_pkg;
  typedef enum logic [2:0] {
    ST_FLT  = 3'd0,  // both drives low, fault or reset
    ST_LS   = 3'd1,  // low-side on, waiting for tick
    ST_WAIT = 3'd2,  // low-side released, waiting for sense
    ST_HS   = 3'd3,  // high-side on
    ST_DEAD = 3'd4,  // fixed dead time after high-side off
    ST_TMO  = 3'd5   // sense timeout, hold low until tick
  } pwm_state_e;
endpackage

// File: rtl/buck_cnt.sv
module buck_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/buck_fsm.sv
module buck_fsm
  import buck_pwm_pkg::*;
#(
  parameter int BLANK_CYC  = 6,
  parameter int DEAD_CYC   = 5,
  parameter int MAX_ON_CYC = 450,
  parameter int LS_TMO_CYC = 50,
  parameter int CW         = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          peak_i,
  input  logic          valley_i,
  input  logic          ls_off_i,
  input  logic          fault_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          hs_en_o,
  output logic          ls_en_o,
  output logic          tmo_o
);
  localparam logic [CW-1:0] BLANK_C   = CW'(BLANK_CYC);
  localparam logic [CW-1:0] ON_LAST   = CW'(MAX_ON_CYC - 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(LS_TMO_CYC - 1);

  pwm_state_e state_q, state_d;
  logic       peak_ok;

  // leading-edge blanking of the current comparator
  assign peak_ok = peak_i && (cnt_i >= BLANK_C);

  always_comb begin
    state_d = state_q;
    if (fault_i) begin
      state_d = ST_FLT;
    end else begin
      unique case (state_q)
        ST_FLT:  state_d = ST_LS;
        ST_LS,
        ST_TMO:  if (tick_i) state_d = valley_i ? ST_LS : ST_WAIT;
        ST_WAIT: begin
          if (ls_off_i)               state_d = ST_HS;
          else if (cnt_i == TMO_LAST) state_d = ST_TMO;
        end
        ST_HS:   if (peak_ok || cnt_i == ON_LAST) state_d = ST_DEAD;
        ST_DEAD: if (cnt_i == DEAD_LAST) state_d = ST_LS;
        default: state_d = ST_FLT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FLT;
    else         state_q <= state_d;
  end

  assign clr_o   = (state_d != state_q);
  assign hs_en_o = (state_q == ST_HS) && !fault_i;
  assign ls_en_o = (state_q == ST_LS) && !fault_i;
  assign tmo_o   = (state_q == ST_TMO);

  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  assert_hs_after_sense_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(ls_off_i));

  assert_on_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HS) |-> (cnt_i <= ON_LAST));

  assert_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || fault_i)
    (state_q == ST_HS && cnt_i < BLANK_C) |=> (state_q == ST_HS));

  assert_valley_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || fault_i)
    (state_q == ST_LS && tick_i && valley_i) |=> ls_en_o);

  assert_dead_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o));
endmodule

// File: rtl/buck_pwm_core.sv
module buck_pwm_core #(
  parameter int BLANK_CYC  = 6,
  parameter int DEAD_CYC   = 5,
  parameter int MAX_ON_CYC = 450,
  parameter int LS_TMO_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic peak_trip_i,
  input  logic valley_lim_i,
  input  logic ls_off_i,
  input  logic fault_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic ls_timeout_o
);
  localparam int M1   = (MAX_ON_CYC > LS_TMO_CYC) ? MAX_ON_CYC : LS_TMO_CYC;
  localparam int CMAX = (M1 > DEAD_CYC) ? M1 : DEAD_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  logic          clr;
  logic [CW-1:0] cnt;

  buck_cnt #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  buck_fsm #(
    .BLANK_CYC  (BLANK_CYC),
    .DEAD_CYC   (DEAD_CYC),
    .MAX_ON_CYC (MAX_ON_CYC),
    .LS_TMO_CYC (LS_TMO_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (osc_tick_i),
    .peak_i   (peak_trip_i),
    .valley_i (valley_lim_i),
    .ls_off_i (ls_off_i),
    .fault_i  (fault_i),
    .cnt_i    (cnt),
    .clr_o    (clr),
    .hs_en_o  (hs_en_o),
    .ls_en_o  (ls_en_o),
    .tmo_o    (ls_timeout_o)
  );
endmodule

// File: tb/buck_pwm_core_bench.sv
module buck_pwm_core_bench;
  localparam int BLANK  = 6;
  localparam int DEAD   = 3;
  localparam int MAXON  = 30;
  localparam int TMO    = 8;
  localparam int PERIOD = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_tick_i = 1'b0, peak_trip_i = 1'b0, valley_lim_i = 1'b0;
  logic ls_off_i = 1'b0, fault_i = 1'b0;
  logic hs_en_o, ls_en_o, ls_timeout_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  buck_pwm_core #(
    .BLANK_CYC(BLANK), .DEAD_CYC(DEAD), .MAX_ON_CYC(MAXON), .LS_TMO_CYC(TMO)
  ) u_buck_pwm_core (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .peak_trip_i(peak_trip_i),
    .valley_lim_i(valley_lim_i), .ls_off_i(ls_off_i), .fault_i(fault_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .ls_timeout_o(ls_timeout_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_period(input int trip_j, input bit valley, input int d, input bit never_off,
                            output int hs_w, output int wait_c, output int gap,
                            output bit tmo_end, output bit ls_end, output int ovl);
    bit hs_seen, ls_back;
    hs_w = 0; wait_c = 0; gap = 0; ovl = 0; hs_seen = 0; ls_back = 0;
    for (int n = 0; n < PERIOD; n++) begin
      @(negedge clk);
      if (hs_en_o && ls_en_o) ovl++;
      if (n > 0) begin
        if (hs_en_o) begin
          hs_seen = 1;
          peak_trip_i = (hs_w >= trip_j);
          hs_w++;
        end else if (!ls_en_o && !hs_seen && !ls_timeout_o) begin
          wait_c++;
          if (!never_off && wait_c >= d) ls_off_i = 1'b1;
        end else if (hs_seen && !ls_en_o && !ls_back) begin
          gap++;
          peak_trip_i = 1'b0;
        end else if (hs_seen && ls_en_o) begin
          ls_back = 1;
          ls_off_i = 1'b0;
          peak_trip_i = 1'b0;
        end
      end
      osc_tick_i   = (n == 0);
      valley_lim_i = valley && (n == 0);
    end
    tmo_end = ls_timeout_o;
    ls_end  = ls_en_o;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int hs_w, wait_c, gap, ovl, expw;
    bit tmo_end, ls_end;

    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 hs in reset", hs_en_o, 0);
    chk("R11 ls in reset", ls_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 ls after reset", ls_en_o, 1);
    chk("R11 hs after reset", hs_en_o, 0);

    // sweep of trip cycle against blanking and on-time limit
    for (int j = 0; j <= MAXON + 2; j++) begin
      int d;
      d = 1 + (j % 3);
      run_period(j, 1'b0, d, 1'b0, hs_w, wait_c, gap, tmo_end, ls_end, ovl);
      expw = ((j > BLANK) ? j : BLANK) + 1;
      if (expw > MAXON) expw = MAXON;
      if (j < BLANK)           chk("R3 blanked trip width", hs_w, expw);
      else if (j >= MAXON - 1) chk("R4 max on-time width", hs_w, expw);
      else                     chk("R2 trip width", hs_w, expw);
      chk("R6 adaptive dead time", wait_c, d);
      chk("R7 fixed dead time", gap, DEAD);
      chk("R12 low-side on at period end", ls_end, 1);
      chk("R8 overlap samples", ovl, 0);
      if (j == 10) chk("R1 pulse present", (hs_w > 0) ? 1 : 0, 1);
    end

    // R5 valley skip
    run_period(BLANK, 1'b1, 1, 1'b0, hs_w, wait_c, gap, tmo_end, ls_end, ovl);
    chk("R5 no high-side pulse", hs_w, 0);
    chk("R5 low-side never released", wait_c, 0);
    chk("R5 low-side at end", ls_end, 1);

    // normal period after skip
    run_period(BLANK + 2, 1'b0, 2, 1'b0, hs_w, wait_c, gap, tmo_end, ls_end, ovl);
    chk("R2 width after skip", hs_w, BLANK + 3);

    // R10 missing sense
    run_period(BLANK, 1'b0, 1, 1'b1, hs_w, wait_c, gap, tmo_end, ls_end, ovl);
    chk("R10 wait before timeout", wait_c, TMO);
    chk("R10 flag held", tmo_end, 1);
    chk("R10 low-side held low", ls_end, 0);
    chk("R10 no high-side pulse", hs_w, 0);
    run_period(BLANK + 4, 1'b0, 1, 1'b0, hs_w, wait_c, gap, tmo_end, ls_end, ovl);
    chk("R10 flag cleared by tick", tmo_end, 0);
    chk("R10 retry width", hs_w, BLANK + 5);
    chk("R1 low-side back after retry", ls_end, 1);

    // R9 fault in the middle of a pulse
    @(negedge clk); osc_tick_i = 1'b1;
    @(negedge clk); osc_tick_i = 1'b0; ls_off_i = 1'b1;
    @(negedge clk);
    chk("R1 high-side on", hs_en_o, 1);
    repeat (4) @(negedge clk);
    fault_i = 1'b1;
    #1;
    chk("R9 hs low same cycle", hs_en_o, 0);
    chk("R9 ls low same cycle", ls_en_o, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 both low held", {31'd0, hs_en_o | ls_en_o}, 0);
    end
    fault_i = 1'b0; ls_off_i = 1'b0;
    @(negedge clk);
    chk("R9 ls on after release", ls_en_o, 1);
    chk("R9 hs off after release", hs_en_o, 0);

    run_period(MAXON + 5, 1'b0, 3, 1'b0, hs_w, wait_c, gap, tmo_end, ls_end, ovl);
    chk("R4 width after fault", hs_w, MAXON);
    chk("R7 gap after fault", gap, DEAD);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule